// File: doc/BRIEF.md
# Write-Protection Command Decoder

This block sits between the write-strobe capture logic of a parallel byte-wide non-volatile memory and its page loader. It watches every latched write for a fixed series of address and data values. Three command series are recognised. One turns write protection on, one turns it off, and one requests a whole-array erase. The block owns the protection flag. While the flag is set, an ordinary write is not handed to the page loader unless it comes right after the unlock key.

Each write arrives as a one-cycle strobe together with its address and data byte. The page-load timer supplies a one-cycle expiry pulse when the gap between two writes has grown too long. That pulse ends any command series that is only partly received. It also closes an open key window, and protection is set when that window closes. For each write the block either raises a pass-write pulse to the page loader or swallows the write. A completed erase series raises a one-cycle erase request. The erase itself is done elsewhere.

The protection flag stands in for a non-volatile bit. It is cleared only by its own power-on reset input. The ordinary soft reset does not touch it.

Top module: `wprot_seq_decoder`

## Requirements
- R1: After reset, pass_we and erase_req are low. prot_on is cleared only by nv_rst_n (power-on), and it keeps its value across a pulse on rst_n.
- R2: With protection off, a write that is not a command step gives a pass_we pulse in the cycle after its wr_stb.
- R3: With protection on, a write that is not preceded by a valid key gives no pass_we pulse.
- R4: The key series is data AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h. After it, writes are passed until the next load_expire. That load_expire sets prot_on, which reads 1 in the following cycle, whether or not data was written.
- R5: With protection on, data writes that follow the key are passed, and protection is still on after the window closes.
- R6: The disable series is AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, 20h at 5555h. prot_on reads 0 in the cycle after the last step. Protection changes only through a series or nv_rst_n.
- R7: The same series with 10h as its last byte gives a one-cycle erase_req pulse in the cycle after the last step, but only when protection is off. When protection is on, no request is made and protection stays on.
- R8: A write that does not match the next expected step returns the decoder to idle. That write is then handled as a plain write: passed if protection is off, dropped if it is on. It does not restart a series.
- R9: A load_expire that arrives partway through a series abandons it, so a later step of that series is not accepted.
- R10: Command addresses are compared on bits 14..0 only. Address bits 16 and 15 have no effect on matching.
- R11: A write that is accepted as a command step never produces pass_we.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Soft reset, active low, asynchronous assert; clears the sequencer only |
| nv_rst_n | input | 1 | Power-on reset of the protection flag, active low |
| wr_stb | input | 1 | One-cycle pulse per latched write |
| wr_addr | input | 17 | Address of the latched write |
| wr_data | input | 8 | Data byte of the latched write |
| load_expire | input | 1 | One-cycle pulse when the page-load timer runs out |
| prot_on | output | 1 | Protection flag |
| pass_we | output | 1 | One-cycle write enable to the page loader |
| erase_req | output | 1 | One-cycle whole-array erase request |

## Verification
A sequencer that has slipped to a wrong step shows on the next write, and only through the outputs. A step that should be accepted leaks out as a pass_we pulse, or a plain write gets swallowed. A wrong protection value shows one cycle later on prot_on. An open key window that fails to close shows as prot_on staying low after load_expire. A lost partial series shows only when its final step fails to change prot_on or to raise erase_req. For this reason the reference model is compared on every cycle, and the series are driven with aborts inserted at each possible step.

// File: rtl/wpd_pkg.sv
package wpd_pkg;

  // Sequencer position: how much of a command series has been seen
  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_K1   = 3'd1,  // first key byte seen
    SQ_K2   = 3'd2,  // second key byte seen
    SQ_OPEN = 3'd3,  // key complete, data writes pass
    SQ_X3   = 3'd4,  // extended series, third step seen
    SQ_X4   = 3'd5,
    SQ_X5   = 3'd6
  } seq_e;

  // Classified write: which command step, if any, a write could be
  typedef enum logic [2:0] {
    TK_NONE  = 3'd0,
    TK_AA_HI = 3'd1,
    TK_55_LO = 3'd2,
    TK_A0_HI = 3'd3,
    TK_80_HI = 3'd4,
    TK_20_HI = 3'd5,
    TK_10_HI = 3'd6
  } tok_e;

endpackage

// File: rtl/wpd_rst_sync.sv
module wpd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/wpd_tok_class.sv
module wpd_tok_class
  import wpd_pkg::*;
#(
  parameter int                    MATCH_W = 15,
  parameter int                    DATA_W  = 8,
  parameter logic [MATCH_W-1:0]    ADDR_HI = 'h5555,
  parameter logic [MATCH_W-1:0]    ADDR_LO = 'h2AAA,
  parameter logic [DATA_W-1:0]     CMD_AA  = 'hAA,
  parameter logic [DATA_W-1:0]     CMD_55  = 'h55,
  parameter logic [DATA_W-1:0]     CMD_A0  = 'hA0,
  parameter logic [DATA_W-1:0]     CMD_80  = 'h80,
  parameter logic [DATA_W-1:0]     CMD_20  = 'h20,
  parameter logic [DATA_W-1:0]     CMD_10  = 'h10
) (
  input  logic [MATCH_W-1:0] addr,
  input  logic [DATA_W-1:0]  data,
  output tok_e               tok
);

  logic hit_hi;
  logic hit_lo;

  assign hit_hi = (addr == ADDR_HI);
  assign hit_lo = (addr == ADDR_LO);

  always_comb begin
    tok = TK_NONE;
    if (hit_hi) begin
      if      (data == CMD_AA) tok = TK_AA_HI;
      else if (data == CMD_A0) tok = TK_A0_HI;
      else if (data == CMD_80) tok = TK_80_HI;
      else if (data == CMD_20) tok = TK_20_HI;
      else if (data == CMD_10) tok = TK_10_HI;
    end else if (hit_lo && (data == CMD_55)) begin
      tok = TK_55_LO;
    end
  end

endmodule

// File: rtl/wpd_prot_flag.sv
module wpd_prot_flag (
  input  logic clk,
  input  logic nv_rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic prot_q
);

  logic prot_d;
  logic prot_en;

  assign prot_en = set_req | clr_req;

  always_comb begin
    prot_d = prot_q;
    if (clr_req)      prot_d = 1'b0;
    else if (set_req) prot_d = 1'b1;
  end

  always_ff @(posedge clk or negedge nv_rst_n) begin
    if (!nv_rst_n)    prot_q <= 1'b0;
    else if (prot_en) prot_q <= prot_d;
  end

  AST_PROT_HOLDS: assert property (@(posedge clk) disable iff (!nv_rst_n)
    (!set_req && !clr_req) |=> $stable(prot_q)); // R6

  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!nv_rst_n)
    set_req |-> !clr_req); // R4

endmodule

// File: rtl/wpd_seq_fsm.sv
module wpd_seq_fsm
  import wpd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  tok_e tok,
  input  logic load_expire,
  input  logic prot_q,
  output logic set_prot,
  output logic clr_prot,
  output logic pass_q,
  output logic erase_q
);

  seq_e state_q, state_d, st_eff;
  logic pass_d, erase_d;
  logic prot_eff, plain_ok;

  // Expiry is taken first: it closes a window or drops a partial series,
  // and the write of the same cycle is judged from the resulting state.
  always_comb begin
    st_eff   = load_expire ? SQ_IDLE : state_q;
    set_prot = load_expire && (state_q == SQ_OPEN);
    prot_eff = prot_q | set_prot;
    plain_ok = !prot_eff;
    state_d  = st_eff;
    pass_d   = 1'b0;
    erase_d  = 1'b0;
    clr_prot = 1'b0;
    if (wr_stb) begin
      state_d = SQ_IDLE;
      pass_d  = plain_ok;
      case (st_eff)
        SQ_IDLE: if (tok == TK_AA_HI) begin
          state_d = SQ_K1; pass_d = 1'b0;
        end
        SQ_K1: if (tok == TK_55_LO) begin
          state_d = SQ_K2; pass_d = 1'b0;
        end
        SQ_K2: begin
          if (tok == TK_A0_HI) begin
            state_d = SQ_OPEN; pass_d = 1'b0;
          end else if (tok == TK_80_HI) begin
            state_d = SQ_X3; pass_d = 1'b0;
          end
        end
        SQ_OPEN: begin
          state_d = SQ_OPEN; pass_d = 1'b1;
        end
        SQ_X3: if (tok == TK_AA_HI) begin
          state_d = SQ_X4; pass_d = 1'b0;
        end
        SQ_X4: if (tok == TK_55_LO) begin
          state_d = SQ_X5; pass_d = 1'b0;
        end
        SQ_X5: begin
          if (tok == TK_20_HI) begin
            clr_prot = 1'b1; pass_d = 1'b0;
          end else if (tok == TK_10_HI) begin
            erase_d = plain_ok; pass_d = 1'b0;
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      pass_q  <= 1'b0;
      erase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      erase_q <= erase_d;
    end
  end

  AST_LOCKED_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |-> ($past(!prot_q) || ($past(state_q) == SQ_OPEN))); // R3

  AST_ERASE_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
    erase_q |-> !prot_q); // R7

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass_q, erase_q})); // R11

  AST_LEAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != SQ_IDLE) && $past(state_q == SQ_IDLE)) |-> $past(wr_stb)); // R8

endmodule

// File: rtl/wprot_seq_decoder.sv
module wprot_seq_decoder
  import wpd_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int MATCH_W     = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nv_rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_expire,
  output logic              prot_on,
  output logic              pass_we,
  output logic              erase_req
);

  localparam int HI_W = ADDR_W - MATCH_W;

  logic rst_s_n, nv_s_n;
  logic set_prot, clr_prot, prot_q;
  tok_e tok;
  logic [HI_W-1:0] unused_addr_hi;

  assign unused_addr_hi = wr_addr[ADDR_W-1:MATCH_W];

  wpd_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_soft (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_s_n));

  wpd_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_nv (
    .clk(clk), .arst_n(nv_rst_n), .srst_n(nv_s_n));

  wpd_tok_class #(.MATCH_W(MATCH_W), .DATA_W(DATA_W)) u_class (
    .addr(wr_addr[MATCH_W-1:0]), .data(wr_data), .tok(tok));

  wpd_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_s_n), .wr_stb(wr_stb), .tok(tok),
    .load_expire(load_expire), .prot_q(prot_q),
    .set_prot(set_prot), .clr_prot(clr_prot),
    .pass_q(pass_we), .erase_q(erase_req));

  wpd_prot_flag u_prot (
    .clk(clk), .nv_rst_n(nv_s_n), .set_req(set_prot), .clr_req(clr_prot),
    .prot_q(prot_q));

  assign prot_on = prot_q;

  AST_PROT_FALL: assert property (@(posedge clk) disable iff (!rst_s_n || !nv_s_n)
    $fell(prot_on) |-> $past(wr_stb)); // R6

  AST_PROT_RISE: assert property (@(posedge clk) disable iff (!rst_s_n || !nv_s_n)
    $rose(prot_on) |-> $past(load_expire)); // R4

endmodule

// File: tb/wprot_seq_decoder_test.sv
`timescale 1ns/1ps
module wprot_seq_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n, nv_rst_n, wr_stb, load_expire;
  logic [16:0] wr_addr;
  logic [7:0]  wr_data;
  logic        prot_on, pass_we, erase_req;

  always #2.5 clk = ~clk;

  wprot_seq_decoder uut (
    .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .load_expire(load_expire),
    .prot_on(prot_on), .pass_we(pass_we), .erase_req(erase_req));

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  bit    run_cmp = 1'b0;
  bit    done    = 1'b0;
  string cur_req = "R1";

  // Behavioural reference: a queue of accepted steps
  localparam logic [22:0] LNG [5] = '{23'h5555AA, 23'h2AAA55, 23'h555580,
                                     23'h5555AA, 23'h2AAA55};
  localparam logic [22:0] W_KEY3 = 23'h5555A0;
  localparam logic [22:0] W_OFF  = 23'h555520;
  localparam logic [22:0] W_ERS  = 23'h555510;

  logic [22:0] hist[$];
  bit mopen = 1'b0, mprot = 1'b0;
  bit exp_pass = 1'b0, exp_erase = 1'b0, exp_prot = 1'b0;

  always @(posedge clk) begin
    logic [22:0] w;
    int n;
    bit pre_ok, hit, p, e;
    p = 1'b0; e = 1'b0;
    if (!nv_rst_n) mprot = 1'b0;
    if (!rst_n) begin
      hist.delete();
      mopen = 1'b0;
    end else begin
      if (load_expire) begin
        if (mopen) mprot = 1'b1;
        mopen = 1'b0;
        hist.delete();
      end
      if (wr_stb) begin
        w = {wr_addr[14:0], wr_data};
        if (mopen) p = 1'b1;
        else begin
          n = hist.size();
          pre_ok = 1'b1;
          for (int i = 0; i < n; i++) if (hist[i] != LNG[i]) pre_ok = 1'b0;
          hit = 1'b0;
          if (pre_ok && n == 2 && w == W_KEY3) begin
            mopen = 1'b1; hist.delete(); hit = 1'b1;
          end else if (pre_ok && n < 5 && w == LNG[n]) begin
            hist.push_back(w); hit = 1'b1;
          end else if (pre_ok && n == 5 && w == W_OFF) begin
            mprot = 1'b0; hist.delete(); hit = 1'b1;
          end else if (pre_ok && n == 5 && w == W_ERS) begin
            e = !mprot; hist.delete(); hit = 1'b1;
          end
          if (!hit) begin
            hist.delete();
            p = !mprot;
          end
        end
      end
    end
    exp_pass  = p;
    exp_erase = e;
    exp_prot  = mprot;
  end

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp && rst_n && nv_rst_n && !done) begin
      chk(pass_we,   exp_pass,  cur_req, "cycle pass_we");
      chk(erase_req, exp_erase, cur_req, "cycle erase_req");
      chk(prot_on,   exp_prot,  cur_req, "cycle prot_on");
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  task automatic wr(input logic [16:0] a, input logic [7:0] d, output logic gp, output logic ge);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    gp = pass_we; ge = erase_req;
    wr_stb = 1'b0;
  endtask

  task automatic expire();
    @(negedge clk); load_expire = 1'b1;
    @(negedge clk); load_expire = 1'b0;
  endtask

  task automatic key3(output logic any_pass);
    logic gp, ge;
    any_pass = 1'b0;
    wr(17'h05555, 8'hAA, gp, ge); any_pass |= gp;
    wr(17'h02AAA, 8'h55, gp, ge); any_pass |= gp;
    wr(17'h05555, 8'hA0, gp, ge); any_pass |= gp;
  endtask

  task automatic six(input logic [7:0] last, output logic any_pass, output logic ge_last);
    logic gp, ge;
    any_pass = 1'b0;
    wr(17'h05555, 8'hAA, gp, ge); any_pass |= gp;
    wr(17'h02AAA, 8'h55, gp, ge); any_pass |= gp;
    wr(17'h05555, 8'h80, gp, ge); any_pass |= gp;
    wr(17'h05555, 8'hAA, gp, ge); any_pass |= gp;
    wr(17'h02AAA, 8'h55, gp, ge); any_pass |= gp;
    wr(17'h05555, last,  gp, ge); any_pass |= gp;
    ge_last = ge;
  endtask

  initial begin
    logic gp, ge, anyp;
    rst_n = 1'b0; nv_rst_n = 1'b0; wr_stb = 1'b0; load_expire = 1'b0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; nv_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_cmp = 1'b1;

    cur_req = "R1";
    chk(prot_on, 1'b0, "R1", "prot after reset");
    chk(pass_we, 1'b0, "R1", "pass after reset");
    chk(erase_req, 1'b0, "R1", "erase after reset");

    cur_req = "R2";
    wr(17'h00123, 8'h3C, gp, ge); chk(gp, 1'b1, "R2", "plain write unprotected");

    cur_req = "R4";
    key3(anyp); chk(anyp, 1'b0, "R11", "key steps not passed");
    chk(prot_on, 1'b0, "R4", "prot before expiry");
    expire(); chk(prot_on, 1'b1, "R4", "prot after expiry");

    cur_req = "R3";
    wr(17'h00200, 8'h11, gp, ge); chk(gp, 1'b0, "R3", "plain write protected");

    cur_req = "R1";
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(prot_on, 1'b1, "R1", "prot kept over soft reset");

    cur_req = "R5";
    key3(anyp);
    wr(17'h00400, 8'h01, gp, ge); chk(gp, 1'b1, "R5", "keyed data 0");
    wr(17'h00401, 8'h02, gp, ge); chk(gp, 1'b1, "R5", "keyed data 1");
    expire(); chk(prot_on, 1'b1, "R5", "prot after keyed write");
    wr(17'h00402, 8'h03, gp, ge); chk(gp, 1'b0, "R3", "window closed");

    cur_req = "R10";
    wr(17'h1D555, 8'hAA, gp, ge);
    wr(17'h0AAAA, 8'h55, gp, ge);
    wr(17'h15555, 8'hA0, gp, ge);
    wr(17'h00500, 8'h44, gp, ge); chk(gp, 1'b1, "R10", "key with high bits set");
    expire();

    cur_req = "R8";
    wr(17'h05555, 8'hAA, gp, ge);
    wr(17'h02AAA, 8'h55, gp, ge);
    wr(17'h00123, 8'h77, gp, ge); chk(gp, 1'b0, "R8", "mismatch dropped when protected");
    wr(17'h05555, 8'hA0, gp, ge); chk(gp, 1'b0, "R8", "late third step rejected");
    wr(17'h00600, 8'h55, gp, ge); chk(gp, 1'b0, "R8", "no window after abort");

    cur_req = "R9";
    wr(17'h05555, 8'hAA, gp, ge);
    wr(17'h02AAA, 8'h55, gp, ge);
    expire();
    wr(17'h05555, 8'hA0, gp, ge);
    wr(17'h00700, 8'h66, gp, ge); chk(gp, 1'b0, "R9", "expiry aborts key");

    cur_req = "R7";
    six(8'h10, anyp, ge); chk(ge, 1'b0, "R7", "no erase when protected");
    chk(prot_on, 1'b1, "R7", "prot after blocked erase");

    cur_req = "R6";
    six(8'h20, anyp, ge); chk(prot_on, 1'b0, "R6", "prot after disable");
    chk(anyp, 1'b0, "R11", "disable steps not passed");
    wr(17'h00800, 8'h99, gp, ge); chk(gp, 1'b1, "R6", "plain write after disable");

    cur_req = "R7";
    six(8'h10, anyp, ge); chk(ge, 1'b1, "R7", "erase when unprotected");
    chk(anyp, 1'b0, "R11", "erase steps not passed");

    cur_req = "R8";
    wr(17'h05555, 8'hAA, gp, ge); chk(gp, 1'b0, "R11", "first step held");
    wr(17'h00040, 8'h12, gp, ge); chk(gp, 1'b1, "R8", "mismatch passed when unprotected");

    cur_req = "R4";
    key3(anyp);
    wr(17'h00900, 8'h5A, gp, ge); chk(gp, 1'b1, "R4", "data after key");
    chk(prot_on, 1'b0, "R4", "prot open window");
    expire(); chk(prot_on, 1'b1, "R4", "prot set after data");

    cur_req = "R1";
    @(negedge clk); nv_rst_n = 1'b0;
    @(negedge clk); nv_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(prot_on, 1'b0, "R1", "prot after power-on reset");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule